// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits between the two request ports of a shared two-port memory and the write strobes of the array. Each clock it samples an enable, a write flag and a word address from the left and from the right port. If both ports are enabled on the same word, one access goes ahead and the other port gets an active-low busy flag. A write from the port that gets busy never reaches the array. Only enables and addresses take part in the decision. Read or write makes no difference.

A static strap input picks the mode. In master mode the block arbitrates and drives its own busy outputs, which are push-pull. In slave mode it does not arbitrate and keeps its busy outputs high. The external busy inputs then work only as write inhibits: the decision comes from another master, or the pin is tied. Requests are registered once. The busy flags, the gated write strobes and the array addresses all leave through one more register, so a write is only qualified when its busy decision is already settled.

Top module: `dpCollisionArb`

## Requirements
- R1: While reset is active, both busy outputs are high and both array write strobes are low.
- R2: A request presented before clock edge n shows on the outputs just after edge n+1. With no collision, no busy is raised and each enabled write reaches its array write strobe. Requests with different addresses do not collide. Requests where either port is disabled do not collide.
- R3: A collision exists only when both ports are enabled on the same address. In master mode, a collision makes exactly one busy output go low, and the two busy outputs are never low together.
- R4: If both ports start matching in the same cycle, the left port wins and the right busy output goes low.
- R5: A port that already held the address in the previous cycle wins over a port that newly arrives at that address. This holds for either side.
- R6: The winner stays fixed as long as the match lasts, including when both ports move together to a new common address. Busy returns high in the output cycle that follows the end of the match.
- R7: The losing port's write strobe stays low while its busy is low. The winning port's write still goes through.
- R8: Whether each access is a read or a write has no effect on which port gets busy.
- R9: In slave mode both busy outputs stay high. A low on a port's busy input blocks that port's write, whatever the addresses are. A high on it lets the write through.
- R10: Each array address output carries that port's request address with the same two-edge delay as its write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | Strap: 1 = arbitrating master, 0 = slave (inhibit only) |
| ceL | input | 1 | Left port enable |
| weL | input | 1 | Left port write request |
| addrL | input | ADDR_W | Left port word address |
| ceR | input | 1 | Right port enable |
| weR | input | 1 | Right port write request |
| addrR | input | ADDR_W | Right port word address |
| busyInLN | input | 1 | Left write inhibit in slave mode, active low |
| busyInRN | input | 1 | Right write inhibit in slave mode, active low |
| busyOutLN | output | 1 | Left busy flag in master mode, active low |
| busyOutRN | output | 1 | Right busy flag in master mode, active low |
| memWeL | output | 1 | Gated left write strobe to the array |
| memAddrL | output | ADDR_W | Left address to the array |
| memWeR | output | 1 | Gated right write strobe to the array |
| memAddrR | output | ADDR_W | Right address to the array |

## Verification
The block is driven with these input patterns:
- ports on distinct addresses, or with one port disabled, to show that no false collision is flagged;
- a simultaneous arrival on one word, which isolates the left-wins tie break;
- staggered arrivals in both orders, which separate "first holder wins" from a fixed left priority;
- read-only collisions, which show that the write flag plays no part;
- a match that persists, including a joint move to a new common word, which shows that the decision is held and then released.

Slave-mode runs tie each busy input low in turn, on colliding and on disjoint addresses, to show that only the external inhibit gates writes.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

  localparam int PORT_L = 0;
  localparam int PORT_R = 1;
  localparam int NPORT  = 2;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // datapath -> control: compare results of the registered request stage
  typedef struct packed {
    logic             match;
    logic [NPORT-1:0] stable;
    logic [NPORT-1:0] ce;
    logic [NPORT-1:0] we;
    logic [NPORT-1:0] extOk;
  } cmpInfo_t;

  // control -> datapath: qualified write strobes
  typedef struct packed {
    logic [NPORT-1:0] wrGo;
  } ctlStrobe_t;

endpackage

// File: rtl/dpcaDatapath.sv
module dpcaDatapath
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NPORT-1:0]              ceIn,
  input  logic [NPORT-1:0]              weIn,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addrIn,
  input  logic [NPORT-1:0]              extBusyN,
  input  ctlStrobe_t                    strobe,
  output cmpInfo_t                      info,
  output logic [NPORT-1:0]              memWe,
  output logic [NPORT-1:0][ADDR_W-1:0]  memAddr
);

  logic [NPORT-1:0]             reqCe, reqWe, reqExtOk, prvCe;
  logic [NPORT-1:0][ADDR_W-1:0] reqAddr, prvAddr;
  logic [NPORT-1:0]             stableV;

  // request stage plus one cycle of history per port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCe    <= '0;
      reqWe    <= '0;
      reqExtOk <= '1;
      prvCe    <= '0;
      reqAddr  <= '0;
      prvAddr  <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        reqCe[p]    <= ceIn[p];
        reqWe[p]    <= weIn[p];
        reqExtOk[p] <= extBusyN[p];
        reqAddr[p]  <= addrIn[p];
        prvCe[p]    <= reqCe[p];
        prvAddr[p]  <= reqAddr[p];
      end
    end
  end

  // a port is "stable" when it held the same enabled address last cycle
  for (genvar g = 0; g < NPORT; g++) begin : gStable
    assign stableV[g] = reqCe[g] & prvCe[g] & (reqAddr[g] == prvAddr[g]);
  end

  always_comb begin
    info.match  = reqCe[PORT_L] & reqCe[PORT_R] & (reqAddr[PORT_L] == reqAddr[PORT_R]);
    info.stable = stableV;
    info.ce     = reqCe;
    info.we     = reqWe;
    info.extOk  = reqExtOk;
  end

  // output stage toward the array: strobe and address move together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWe   <= '0;
      memAddr <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        memWe[p]   <= strobe.wrGo[p];
        memAddr[p] <= reqAddr[p];
      end
    end
  end

endmodule

// File: rtl/dpcaControl.sv
module dpcaControl
  import dpca_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  cmpInfo_t         info,
  output ctlStrobe_t       strobe,
  output logic [NPORT-1:0] busyN
);

  owner_e ownerQ, ownerNext;
  logic [NPORT-1:0] lose;

  always_comb begin
    if (!masterMode || !info.match) begin
      ownerNext = OWN_NONE;
    end else if (ownerQ == OWN_NONE) begin
      // fresh collision: incumbent wins, tie goes left
      ownerNext = (info.stable[PORT_R] && !info.stable[PORT_L]) ? OWN_RIGHT : OWN_LEFT;
    end else begin
      ownerNext = ownerQ;
    end
  end

  always_comb begin
    lose[PORT_L] = masterMode & info.match & (ownerNext == OWN_RIGHT);
    lose[PORT_R] = masterMode & info.match & (ownerNext == OWN_LEFT);
    for (int p = 0; p < NPORT; p++) begin
      strobe.wrGo[p] = info.ce[p] & info.we[p] &
                       (masterMode ? ~lose[p] : info.extOk[p]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= OWN_NONE;
      busyN  <= '1;
    end else begin
      ownerQ <= ownerNext;
      busyN  <= ~lose;
    end
  end

endmodule

// File: rtl/dpCollisionArb.sv
module dpCollisionArb
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              ceL,
  input  logic              weL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              ceR,
  input  logic              weR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInLN,
  input  logic              busyInRN,
  output logic              busyOutLN,
  output logic              busyOutRN,
  output logic              memWeL,
  output logic [ADDR_W-1:0] memAddrL,
  output logic              memWeR,
  output logic [ADDR_W-1:0] memAddrR
);

  cmpInfo_t                     info;
  ctlStrobe_t                   strobe;
  logic [NPORT-1:0]             busyN, memWe;
  logic [NPORT-1:0][ADDR_W-1:0] memAddr;

  dpcaDatapath #(.ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ceIn     ({ceR, ceL}),
    .weIn     ({weR, weL}),
    .addrIn   ({addrR, addrL}),
    .extBusyN ({busyInRN, busyInLN}),
    .strobe   (strobe),
    .info     (info),
    .memWe    (memWe),
    .memAddr  (memAddr)
  );

  dpcaControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .info       (info),
    .strobe     (strobe),
    .busyN      (busyN)
  );

  assign busyOutLN = busyN[PORT_L];
  assign busyOutRN = busyN[PORT_R];
  assign memWeL    = memWe[PORT_L];
  assign memWeR    = memWe[PORT_R];
  assign memAddrL  = memAddr[PORT_L];
  assign memAddrR  = memAddr[PORT_R];

endmodule

// File: rtl/dpcaChecker.sv
module dpcaChecker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              ceL,
  input logic              weL,
  input logic [ADDR_W-1:0] addrL,
  input logic              ceR,
  input logic              weR,
  input logic [ADDR_W-1:0] addrR,
  input logic              busyOutLN,
  input logic              busyOutRN,
  input logic              memWeL,
  input logic [ADDR_W-1:0] memAddrL,
  input logic              memWeR,
  input logic [ADDR_W-1:0] memAddrR
);

  // R3
  one_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyOutLN && !busyOutRN));

  // R7
  lose_left_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyOutLN |-> !memWeL);

  // R7
  lose_right_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyOutRN |-> !memWeR);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (busyOutLN && busyOutRN));

  // R2
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWeL |-> ($past(ceL, 2) && $past(weL, 2)));

  // R10
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWeR |-> (memAddrR == $past(addrR, 2)));

endmodule

bind dpCollisionArb dpcaChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .ceL(ceL), .weL(weL), .addrL(addrL),
  .ceR(ceR), .weR(weR), .addrR(addrR),
  .busyOutLN(busyOutLN), .busyOutRN(busyOutRN),
  .memWeL(memWeL), .memAddrL(memAddrL),
  .memWeR(memWeR), .memAddrR(memAddrR)
);

// File: tb/sim_dpCollisionArb.sv
module sim_dpCollisionArb;
  localparam int AW = 4;

  logic clk = 0, rstN = 0, masterMode = 1;
  logic ceL = 0, weL = 0, ceR = 0, weR = 0, busyInLN = 1, busyInRN = 1;
  logic [AW-1:0] addrL = '0, addrR = '0;
  logic busyOutLN, busyOutRN, memWeL, memWeR;
  logic [AW-1:0] memAddrL, memAddrR;

  always #2 clk = ~clk;  // 250 MHz

  dpCollisionArb #(.ADDR_W(AW)) u0 (.*);

  typedef struct {
    int            due;
    logic          bL, bR, wL, wR;
    logic [AW-1:0] aL, aR;
    string         tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0, nChk = 0, nFail = 0;
  bit finished = 0;

  // reference state
  logic          mCe[2];
  logic [AW-1:0] mA[2];
  int            mOwn;

  always @(posedge clk) begin
    cyc++;
    #1;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t e;
      e = sbq.pop_front();
      nChk++;
      if (busyOutLN !== e.bL || busyOutRN !== e.bR || memWeL !== e.wL || memWeR !== e.wR ||
          memAddrL !== e.aL || memAddrR !== e.aR) begin
        nFail++;
        $display("FAIL %s: got bL=%b bR=%b wL=%b wR=%b aL=%0d aR=%0d exp bL=%b bR=%b wL=%b wR=%b aL=%0d aR=%0d",
                 e.tag, busyOutLN, busyOutRN, memWeL, memWeR, memAddrL, memAddrR,
                 e.bL, e.bR, e.wL, e.wR, e.aL, e.aR);
      end
    end
  end

  task automatic drive(input logic cl, input int al, input logic wl,
                       input logic cr, input int ar, input logic wr,
                       input logic bil, input logic bir, input string tag);
    item_t e;
    logic stL, stR, match, loseL, loseR;
    @(negedge clk);
    ceL = cl; addrL = AW'(al); weL = wl;
    ceR = cr; addrR = AW'(ar); weR = wr;
    busyInLN = bil; busyInRN = bir;
    stL   = cl && mCe[0] && (AW'(al) == mA[0]);
    stR   = cr && mCe[1] && (AW'(ar) == mA[1]);
    match = cl && cr && (AW'(al) == AW'(ar));
    if (!masterMode || !match) mOwn = 0;
    else if (mOwn == 0) mOwn = (stR && !stL) ? 2 : 1;
    loseL = masterMode && match && mOwn == 2;
    loseR = masterMode && match && mOwn == 1;
    e.due = cyc + 2;
    e.bL = !loseL; e.bR = !loseR;
    e.wL = cl && wl && (masterMode ? !loseL : bil);
    e.wR = cr && wr && (masterMode ? !loseR : bir);
    e.aL = AW'(al); e.aR = AW'(ar);
    e.tag = tag;
    sbq.push_back(e);
    mCe[0] = cl; mA[0] = AW'(al);
    mCe[1] = cr; mA[1] = AW'(ar);
  endtask

  task automatic doReset(input logic mode);
    repeat (3) drive(0, 0, 0, 0, 0, 0, 1, 1, "R2 idle drain");
    repeat (3) @(negedge clk);
    rstN = 0;
    masterMode = mode;
    repeat (2) @(negedge clk);
    nChk++;
    if (busyOutLN !== 1 || busyOutRN !== 1 || memWeL !== 0 || memWeR !== 0) begin
      nFail++;
      $display("FAIL R1: got bL=%b bR=%b wL=%b wR=%b exp 1 1 0 0",
               busyOutLN, busyOutRN, memWeL, memWeR);
    end
    mCe[0] = 0; mCe[1] = 0; mA[0] = '0; mA[1] = '0; mOwn = 0;
    rstN = 1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    mCe[0] = 0; mCe[1] = 0; mA[0] = '0; mA[1] = '0; mOwn = 0;
    doReset(1);
    // R2 disjoint addresses and disabled port
    drive(1, 5, 1, 1, 9, 1, 1, 1, "R2 distinct writes");
    drive(1, 6, 1, 0, 6, 1, 1, 1, "R2 right disabled");
    drive(0, 6, 1, 1, 6, 1, 1, 1, "R2 left disabled");
    // R4 simultaneous arrival, R7 gating, R6 hold and release
    drive(1, 3, 1, 1, 3, 1, 1, 1, "R4 tie goes left");
    drive(1, 3, 1, 1, 3, 1, 1, 1, "R6 hold");
    drive(1, 3, 1, 1, 3, 1, 1, 1, "R7 right write blocked");
    drive(1, 3, 1, 0, 3, 1, 1, 1, "R6 release");
    // R5 incumbent left
    drive(1, 7, 1, 0, 0, 0, 1, 1, "R5 left alone");
    drive(1, 7, 1, 1, 7, 1, 1, 1, "R5 left incumbent wins");
    drive(0, 0, 0, 0, 0, 0, 1, 1, "R2 idle");
    // R5 incumbent right, R7 left blocked
    drive(0, 0, 0, 1, 7, 1, 1, 1, "R5 right alone");
    drive(1, 7, 1, 1, 7, 0, 1, 1, "R5 right incumbent wins");
    drive(1, 7, 1, 1, 7, 1, 1, 1, "R7 left write blocked");
    drive(1, 12, 1, 1, 12, 1, 1, 1, "R6 joint move keeps owner");
    drive(1, 8, 1, 1, 12, 1, 1, 1, "R6 left moves away");
    drive(1, 8, 1, 1, 12, 1, 1, 1, "R2 after release");
    // R8 reads only
    drive(0, 0, 0, 1, 2, 0, 1, 1, "R8 right reader alone");
    drive(1, 2, 0, 1, 2, 0, 1, 1, "R8 read collision busy left");
    drive(1, 2, 0, 1, 2, 0, 1, 1, "R8 read collision held");
    drive(1, 1, 0, 1, 1, 0, 1, 1, "R8 read tie");
    drive(0, 0, 0, 0, 0, 0, 1, 1, "R8 idle");
    drive(1, 4, 1, 1, 4, 0, 1, 1, "R8 mixed tie");
    drive(0, 0, 0, 0, 0, 0, 1, 1, "R10 idle");
    drive(1, 15, 1, 1, 0, 1, 1, 1, "R10 addr edges");
    // R9 slave mode
    doReset(0);
    drive(1, 3, 1, 1, 3, 1, 1, 1, "R9 slave collision no busy");
    drive(1, 3, 1, 1, 3, 1, 0, 1, "R9 left inhibited");
    drive(1, 5, 1, 1, 9, 1, 1, 0, "R9 right inhibited disjoint");
    drive(1, 5, 1, 1, 9, 1, 0, 0, "R9 both inhibited");
    drive(1, 5, 0, 1, 9, 0, 0, 0, "R9 reads under inhibit");
    drive(1, 5, 1, 1, 9, 1, 1, 1, "R9 released");
    repeat (3) drive(0, 0, 0, 0, 0, 0, 1, 1, "R2 final idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule